// File: doc/BRIEF.md
# Z-Track Trigger Tower Finder

This block takes z-bin hit vectors from seven z-position layers in every azimuthal segment and flags tracks that point back to the interaction point. The seven layers are three cathode layers, two layers of a middle wire superlayer and two layers of an outer wire superlayer. A tower index stands for one polar angle. A tower counts as a track when the layers agree on that same tower index. The towers that pass in all segments are summed, and the result goes to the global trigger as a 2-bit count that saturates.

Each segment's hits are ORed with those of the next segment before the towers are tested, so a track near a segment boundary is not lost. A track that appears in two segments after this OR is counted in both. No de-duplication is done. The block is a free-running pipeline with a fixed latency and no handshake. A result comes out every cycle, and a valid flag shows once the pipeline holds data taken after reset.

Top module: `ztt_tower_finder`

## Requirements
- R1: Input bit (l*NSEG + s)*NTOWER + t of `hits_i` is layer l, segment s, tower t. Layers 0, 1 and 2 are cathode layers, layers 3 and 4 are the middle superlayer, and layers 5 and 6 are the outer superlayer. Tower t of segment s qualifies when at least two cathode layers, at least one middle layer and at least one outer layer all have a hit at tower t.
- R2: Hits on different tower indices never combine, so a qualifying set needs every hit at the same tower index.
- R3: Segment s works on its own hits ORed with those of segment (s+1) mod NSEG. Each segment's qualifying towers are counted separately, so one track can be counted twice.
- R4: A tower with a hit in only one cathode layer never qualifies, whatever the wire layers hold.
- R5: A tower with no middle-layer hit, or with no outer-layer hit, never qualifies.
- R6: `count_o` is the number of qualifying towers over all segments, saturated at 3.
- R7: The hits sampled at one rising edge appear on `count_o` just after the fourth rising edge counted from that one. A new result comes every cycle.
- R8: While `rst_ni` is low, `count_o` is 0 and `valid_o` is 0. After release, `valid_o` goes to 1 after the fourth rising edge and stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hits_i | input | 7*NSEG*NTOWER | Z-bin hit bits per layer, segment and tower |
| count_o | output | 2 | Saturated count of tracks from the interaction point |
| valid_o | output | 1 | Pipeline filled since reset |

## Verification
The bench builds the block with NSEG=4 and NTOWER=6. This keeps the input at 168 bits, so specific tracks can be placed by hand. It also makes the wrap-around from the last segment to segment 0 easy to reach, and random patterns reach the saturation limit often. Hand-placed patterns cover boundary sharing, misaligned towers, a lone cathode hit and missing wire layers. Back-to-back random vectors then check the fixed latency every cycle.

// File: rtl/ztt_pkg.sv
package ztt_pkg;
  localparam int NUM_LAYERS = 7;
  localparam int CATH_BASE  = 0;
  localparam int MID_BASE   = 3;
  localparam int OUTER_BASE = 5;
  localparam int CNT_W      = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int PIPE_DEPTH = 4;
endpackage

// File: rtl/ztt_seg_or.sv
module ztt_seg_or
  import ztt_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int NTOWER = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LAYERS*NSEG*NTOWER-1:0] hits_i,
  output logic [NUM_LAYERS*NSEG*NTOWER-1:0] eff_o
);
  localparam int W = NUM_LAYERS*NSEG*NTOWER;

  logic [W-1:0] eff_d;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int OWN = (l*NSEG + s)*NTOWER;
      localparam int NXT = (l*NSEG + ((s+1) % NSEG))*NTOWER;
      assign eff_d[OWN +: NTOWER] = hits_i[OWN +: NTOWER] | hits_i[NXT +: NTOWER];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_o <= '0;
    else         eff_o <= eff_d;
  end
endmodule

// File: rtl/ztt_tower_qual.sv
module ztt_tower_qual
  import ztt_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int NTOWER = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LAYERS*NSEG*NTOWER-1:0] eff_i,
  output logic [NSEG*NTOWER-1:0]            qual_o
);
  localparam int NQ = NSEG*NTOWER;

  logic [NQ-1:0] qual_d;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    for (genvar t = 0; t < NTOWER; t++) begin : g_tower
      logic c0, c1, c2, mid, outer;
      assign c0    = eff_i[((CATH_BASE+0)*NSEG + s)*NTOWER + t];
      assign c1    = eff_i[((CATH_BASE+1)*NSEG + s)*NTOWER + t];
      assign c2    = eff_i[((CATH_BASE+2)*NSEG + s)*NTOWER + t];
      assign mid   = eff_i[((MID_BASE+0)*NSEG + s)*NTOWER + t]
                   | eff_i[((MID_BASE+1)*NSEG + s)*NTOWER + t];
      assign outer = eff_i[((OUTER_BASE+0)*NSEG + s)*NTOWER + t]
                   | eff_i[((OUTER_BASE+1)*NSEG + s)*NTOWER + t];
      // 2-of-3 cathode majority, same tower index throughout
      assign qual_d[s*NTOWER + t] = ((c0 & c1) | (c0 & c2) | (c1 & c2)) & mid & outer;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_o <= '0;
    else         qual_o <= qual_d;
  end
endmodule

// File: rtl/ztt_track_count.sv
module ztt_track_count
  import ztt_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int NTOWER = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSEG*NTOWER-1:0] qual_i,
  output logic [CNT_W-1:0]       count_o
);
  logic [NSEG*CNT_W-1:0] seg_d, seg_q;
  logic [CNT_W-1:0]      total_d;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_comb begin
      logic [CNT_W-1:0] acc;
      acc = '0;
      for (int t = 0; t < NTOWER; t++) begin
        if (qual_i[s*NTOWER + t] && acc != CNT_MAX) acc = acc + 1'b1;
      end
      seg_d[s*CNT_W +: CNT_W] = acc;
    end
  end

  always_comb begin
    logic [CNT_W:0] sum;
    sum = '0;
    for (int s = 0; s < NSEG; s++) begin
      sum = sum + {1'b0, seg_q[s*CNT_W +: CNT_W]};
      if (sum > {1'b0, CNT_MAX}) sum = {1'b0, CNT_MAX};
    end
    total_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '0;
      count_o <= '0;
    end else begin
      seg_q   <= seg_d;
      count_o <= total_d;
    end
  end

  // R6: a nonzero count needs a qualifying tower two stages earlier
  p_count_needs_tower_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> ($past(qual_i, 2) != '0));
endmodule

// File: rtl/ztt_tower_finder.sv
module ztt_tower_finder
  import ztt_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int NTOWER = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LAYERS*NSEG*NTOWER-1:0] hits_i,
  output logic [CNT_W-1:0]                 count_o,
  output logic                             valid_o
);
  localparam int W  = NUM_LAYERS*NSEG*NTOWER;
  localparam int NQ = NSEG*NTOWER;

  logic [W-1:0]          eff;
  logic [NQ-1:0]         qual;
  logic [PIPE_DEPTH-1:0] fill_q;

  ztt_seg_or #(.NSEG(NSEG), .NTOWER(NTOWER)) u_seg_or (
    .clk_i(clk_i), .rst_ni(rst_ni), .hits_i(hits_i), .eff_o(eff)
  );

  ztt_tower_qual #(.NSEG(NSEG), .NTOWER(NTOWER)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .eff_i(eff), .qual_o(qual)
  );

  ztt_track_count #(.NSEG(NSEG), .NTOWER(NTOWER)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .qual_i(qual), .count_o(count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= {fill_q[PIPE_DEPTH-2:0], 1'b1};
  end

  assign valid_o = fill_q[PIPE_DEPTH-1];

  // R8: once filled, valid stays up until reset
  p_valid_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  // R7: an empty input gives an empty count after four edges
  p_zero_in_zero_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(hits_i, 4) == '0) |-> (count_o == '0));

  // R4: hits from cathode layers only never form a track
  p_cath_only_no_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(hits_i[W-1:3*NSEG*NTOWER], 4) == '0) |-> (count_o == '0));
endmodule

// File: tb/ztt_tower_finder_tb_top.sv
module ztt_tower_finder_tb_top;
  localparam int NSEG   = 4;
  localparam int NTOWER = 6;
  localparam int NL     = 7;
  localparam int W      = NL*NSEG*NTOWER;

  typedef struct {
    int         stamp;
    logic [1:0] exp;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] hits = '0;
  logic [1:0]   count;
  logic         valid;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  ztt_tower_finder #(.NSEG(NSEG), .NTOWER(NTOWER)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hits_i(hits), .count_o(count), .valid_o(valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int bi(int l, int s, int t);
    return (l*NSEG + s)*NTOWER + t;
  endfunction

  // Expected count from the requirements (R1, R3, R6)
  function automatic logic [1:0] model(logic [W-1:0] h);
    int n = 0;
    for (int s = 0; s < NSEG; s++) begin
      for (int t = 0; t < NTOWER; t++) begin
        int  nc = 0;
        bit  m, o;
        logic [NL-1:0] e;
        for (int l = 0; l < NL; l++)
          e[l] = h[bi(l, s, t)] | h[bi(l, (s+1) % NSEG, t)];
        nc = e[0] + e[1] + e[2];
        m  = e[3] | e[4];
        o  = e[5] | e[6];
        if (nc >= 2 && m && o) n++;
      end
    end
    return (n > 3) ? 2'd3 : 2'(n);
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] h, string tag, bit use_exp = 0, logic [1:0] exp = 0);
    item_t it;
    @(negedge clk);
    hits     = h;
    it.stamp = cyc;
    it.exp   = use_exp ? exp : model(h);
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result for a vector driven at stamp appears four edges later (R7)
  always @(negedge clk) begin
    if (rst_ni && sb_q.size() > 0 && sb_q[0].stamp + 4 == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      check({it.tag, " R7 valid"}, {1'b0, valid}, 2'd1);
      check(it.tag, count, it.exp);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] h;
    repeat (3) @(negedge clk);
    check("R8 reset count", count, 2'd0);
    check("R8 reset valid", {1'b0, valid}, 2'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 valid low after 3 edges", {1'b0, valid}, 2'd0);
    @(negedge clk);
    check("R8 valid high after 4 edges", {1'b0, valid}, 2'd1);

    drive('0, "R1 empty", 1, 2'd0);

    // Full track in segment 1 tower 2: seen by segments 1 and 0
    h = '0;
    h[bi(0,1,2)] = 1; h[bi(1,1,2)] = 1; h[bi(3,1,2)] = 1; h[bi(5,1,2)] = 1;
    drive(h, "R1 R3 boundary double count", 1, 2'd2);

    // Track in segment 0 also seen by the last segment via wrap-around
    h = '0;
    h[bi(1,0,4)] = 1; h[bi(2,0,4)] = 1; h[bi(4,0,4)] = 1; h[bi(6,0,4)] = 1;
    drive(h, "R3 wrap-around", 1, 2'd2);

    h = '0;
    h[bi(0,1,2)] = 1; h[bi(3,1,2)] = 1; h[bi(4,1,2)] = 1; h[bi(5,1,2)] = 1;
    drive(h, "R4 single cathode", 1, 2'd0);

    h = '0;
    h[bi(0,2,1)] = 1; h[bi(2,2,1)] = 1; h[bi(3,2,1)] = 1;
    drive(h, "R5 no outer", 1, 2'd0);

    h = '0;
    h[bi(0,2,1)] = 1; h[bi(1,2,1)] = 1; h[bi(6,2,1)] = 1;
    drive(h, "R5 no middle", 1, 2'd0);

    h = '0;
    h[bi(0,1,2)] = 1; h[bi(1,1,2)] = 1; h[bi(3,1,2)] = 1; h[bi(5,1,3)] = 1;
    drive(h, "R2 misaligned tower", 1, 2'd0);

    // Outer hit only in segment 2: combined only by segment 1
    h = '0;
    h[bi(0,1,2)] = 1; h[bi(1,1,2)] = 1; h[bi(3,1,2)] = 1; h[bi(5,2,2)] = 1;
    drive(h, "R3 split across segments", 1, 2'd1);

    h = '0;
    for (int t = 0; t < 3; t++) begin
      h[bi(0,3,t)] = 1; h[bi(2,3,t)] = 1; h[bi(4,3,t)] = 1; h[bi(5,3,t)] = 1;
    end
    drive(h, "R6 saturate", 1, 2'd3);

    drive('1, "R6 all hits", 1, 2'd3);

    for (int i = 0; i < 200; i++) begin
      for (int b = 0; b < W; b++) h[b] = ($urandom_range(0, 2) == 0);
      drive(h, "R7 random back-to-back");
    end

    drive('0, "R1 flush", 1, 2'd0);
    while (sb_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule